// File: doc/BRIEF.md
# Dual-Segment RAM Write Guard

This block sits in front of a RAM write path and decides, for every write request, whether the write may proceed. Two programmable word-address segments are held in local registers. Each segment has a start word, an end word and a two-bit enable field with one bit for user-data accesses and one for supervisor-data accesses. A mode input picks the meaning of the segments. In block mode a segment is a forbidden zone. In the other mode the enabled segments are the only places that can be written.

Configuration registers are written and read through a small select/data port. A write that sets bits outside a register's defined fields raises a one-cycle hardware error pulse. The stored value is still taken, with the undefined bits dropped. Each request gets a registered allow/deny answer. A denied write also gets a fault strobe that carries a protection fault code and a write flag, meant for an external fault status register. The memory array is outside this block and is not touched on a denial.

Top module: `wprot_guard`

## Requirements
- R1: After a synchronous reset, every start, end and enable field is zero, so all four readbacks return 0.
- R2: Register select encoding: 0 = segment 0 start, 1 = segment 0 end, 2 = segment 1 start, 3 = segment 1 end.
  - A start write stores bits 22:0 as the start word and bits 24:23 as the enable field.
  - An end write stores bits 22:0 as the end word.
  - A start readback returns the start word in bits 22:0 and the enable field in bits 24:23.
  - An end readback returns only the end word in bits 22:0.
  - Readback appears one cycle after `cfg_rsel` is presented.
- R3: `cfg_err` pulses for one cycle after a start write with any of bits 31:25 set, or after an end write with any of bits 31:23 set. No other write raises it, and no cycle without a write raises it.
- R4: The compared word address is taken from byte address bits 22:2. Higher bits are ignored. A segment is hit when start <= word < end, so the end word itself is outside the segment.
- R5: `req_size` encoding: 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. For a doubleword, the upper-bound test uses the word address with bit 0 forced to 1, so both words must lie below the end.
- R6: A segment takes part in a request only if its enable bit for that request's privilege is set. Enable bit 0 applies when `req_super`=0 (user). Enable bit 1 applies when `req_super`=1 (supervisor).
- R7: With `blk_mode`=1, a write that hits any segment is denied, and all others are allowed.
- R8: With `blk_mode`=0, a write is denied unless it hits at least one segment.
- R9: While both enable fields are zero, every write is allowed in either mode.
- R10: The answer is registered.
  - `resp_valid` and `resp_allow` appear one cycle after `req_valid`.
  - A denial also raises `fault_stb` with `fault_code`=4 and `fault_wr`=1 in that same cycle.
  - Without a denial, `fault_stb`, `fault_code` and `fault_wr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register selected for write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rsel | input | 2 | Register selected for readback |
| cfg_rdata | output | 32 | Registered readback data |
| cfg_err | output | 1 | Hardware error pulse for illegal write bits |
| blk_mode | input | 1 | 1: segments forbid writes; 0: segments are the only writable zones |
| req_valid | input | 1 | Write request present |
| req_addr | input | 32 | Byte address of the write |
| req_size | input | 2 | Access size code |
| req_super | input | 1 | 1: supervisor data access, 0: user data access |
| resp_valid | output | 1 | Answer valid for the previous cycle's request |
| resp_allow | output | 1 | 1 when the write may proceed |
| fault_stb | output | 1 | Protection fault strobe |
| fault_code | output | 4 | Fault code, 4 on a protection fault |
| fault_wr | output | 1 | Fault came from a write access |

## Verification
Every result of this block is due exactly one rising edge after the stimulus that causes it:
- the allow/deny answer and fault strobe follow the request edge;
- the readback word follows the select edge;
- the error pulse follows the configuration write edge.

A configuration write takes effect for a request presented in the next cycle. The bench drives inputs on falling edges and runs a behavioural model on each rising edge that predicts the next values of all outputs. It compares every output with that prediction on the following falling edge. Because both sides use the same one-edge latency, a slip of one cycle in any path shows up as a mismatch.

// File: rtl/wprot_pkg.sv
package wprot_pkg;
  // access size codes seen on the request port
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  // privilege classes that index the per-segment enable field
  localparam int PRIV_USER  = 0;
  localparam int PRIV_SUPER = 1;
  localparam int PRIV_CLASSES = 2;
endpackage

// File: rtl/wprot_regs.sv
module wprot_regs #(
  parameter int NUM_SEG = 2,
  parameter int SEG_W   = 23,
  parameter int EN_W    = 2,
  parameter int DATA_W  = 32,
  parameter int SEL_W   = 2
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             cfg_wr,
  input  logic [SEL_W-1:0]                 cfg_sel,
  input  logic [DATA_W-1:0]                cfg_wdata,
  input  logic [SEL_W-1:0]                 cfg_rsel,
  output logic [NUM_SEG-1:0][SEG_W-1:0]    seg_start,
  output logic [NUM_SEG-1:0][SEG_W-1:0]    seg_stop,
  output logic [NUM_SEG-1:0][EN_W-1:0]     seg_en,
  output logic [DATA_W-1:0]                cfg_rdata,
  output logic                             cfg_err
);
  localparam int START_TOP = SEG_W + EN_W;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    logic wr_start, wr_stop;
    assign wr_start = cfg_wr && (cfg_sel == SEL_W'(2 * g));
    assign wr_stop  = cfg_wr && (cfg_sel == SEL_W'(2 * g + 1));

    always_ff @(posedge clk) begin
      if (rst) begin
        seg_start[g] <= '0;
        seg_en[g]    <= '0;
        seg_stop[g]  <= '0;
      end else begin
        if (wr_start) begin
          seg_start[g] <= cfg_wdata[SEG_W-1:0];
          seg_en[g]    <= cfg_wdata[START_TOP-1:SEG_W];
        end
        if (wr_stop) begin
          seg_stop[g] <= cfg_wdata[SEG_W-1:0];
        end
      end
    end
  end

  // undefined bits differ for start (enable field present) and end registers
  logic illegal_bits;
  always_comb begin
    if (cfg_sel[0]) illegal_bits = |cfg_wdata[DATA_W-1:SEG_W];
    else            illegal_bits = |cfg_wdata[DATA_W-1:START_TOP];
  end

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (cfg_rsel == SEL_W'(2 * i))
        rd_next[START_TOP-1:0] = {seg_en[i], seg_start[i]};
      else if (cfg_rsel == SEL_W'(2 * i + 1))
        rd_next[SEG_W-1:0] = seg_stop[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err   <= 1'b0;
      cfg_rdata <= '0;
    end else begin
      cfg_err   <= cfg_wr && illegal_bits;
      cfg_rdata <= rd_next;
    end
  end

  // R3: illegal start bits raise the error pulse
  a_r3_start_err: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && !cfg_sel[0] && (|cfg_wdata[DATA_W-1:START_TOP]) |=> cfg_err);
  // R3: illegal end bits raise the error pulse
  a_r3_stop_err: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && cfg_sel[0] && (|cfg_wdata[DATA_W-1:SEG_W]) |=> cfg_err);
  // R3: no write, no error
  a_r3_quiet: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> !cfg_err);
  // R1: reset clears every field
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (seg_start == '0 && seg_stop == '0 && seg_en == '0));
endmodule

// File: rtl/wprot_seg_match.sv
module wprot_seg_match #(
  parameter int SEG_W = 23,
  parameter int EN_W  = 2
) (
  input  logic [SEG_W-1:0] waddr,
  input  logic             dword,
  input  logic             super_acc,
  input  logic [SEG_W-1:0] seg_start,
  input  logic [SEG_W-1:0] seg_stop,
  input  logic [EN_W-1:0]  seg_en,
  output logic             hit,
  output logic             armed
);
  logic [SEG_W-1:0] upper;
  logic             class_on;

  // a doubleword must also fit its odd word below the end
  assign upper    = waddr | SEG_W'(dword);
  assign class_on = seg_en[super_acc];
  assign armed    = |seg_en;
  assign hit      = class_on && (waddr >= seg_start) && (upper < seg_stop);
endmodule

// File: rtl/wprot_decide.sv
module wprot_decide #(
  parameter int          NUM_SEG   = 2,
  parameter int          CODE_W    = 4,
  parameter logic [3:0]  PROT_CODE = 4'd4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               blk_mode,
  input  logic [NUM_SEG-1:0] hits,
  input  logic [NUM_SEG-1:0] armed,
  output logic               resp_valid,
  output logic               resp_allow,
  output logic               fault_stb,
  output logic [CODE_W-1:0]  fault_code,
  output logic               fault_wr
);
  logic any_hit, any_armed, deny;

  assign any_hit   = |hits;
  assign any_armed = |armed;
  assign deny      = any_armed && (blk_mode ? any_hit : !any_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_allow <= 1'b0;
      fault_stb  <= 1'b0;
      fault_code <= '0;
      fault_wr   <= 1'b0;
    end else begin
      resp_valid <= req_valid;
      resp_allow <= req_valid && !deny;
      fault_stb  <= req_valid && deny;
      fault_code <= (req_valid && deny) ? CODE_W'(PROT_CODE) : '0;
      fault_wr   <= req_valid && deny;
    end
  end

  // R10: a fault only accompanies a valid denial with the protection code
  a_r10_fault_is_deny: assert property (@(posedge clk) disable iff (rst)
    fault_stb |-> (resp_valid && !resp_allow && fault_wr && fault_code == CODE_W'(PROT_CODE)));
  // R9: nothing armed means the write passes
  a_r9_bypass: assert property (@(posedge clk) disable iff (rst)
    req_valid && !any_armed |=> resp_allow);
  // R7: block mode denies a hit
  a_r7_block_hit: assert property (@(posedge clk) disable iff (rst)
    req_valid && blk_mode && any_hit |=> !resp_allow);
  // R8: allow-only mode denies a miss when armed
  a_r8_miss_denied: assert property (@(posedge clk) disable iff (rst)
    req_valid && !blk_mode && any_armed && !any_hit |=> (!resp_allow && fault_stb));
endmodule

// File: rtl/wprot_guard.sv
module wprot_guard #(
  parameter int         NUM_SEG   = 2,
  parameter int         SEG_W     = 23,
  parameter int         EN_W      = 2,
  parameter int         DATA_W    = 32,
  parameter int         ADDR_W    = 32,
  parameter int         WA_LO     = 2,
  parameter int         WA_HI     = 22,
  parameter int         CODE_W    = 4,
  parameter logic [3:0] PROT_CODE = 4'd4,
  parameter int         SEL_W     = $clog2(2 * NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              cfg_err,
  input  logic              blk_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_super,
  output logic              resp_valid,
  output logic              resp_allow,
  output logic              fault_stb,
  output logic [CODE_W-1:0] fault_code,
  output logic              fault_wr
);
  import wprot_pkg::*;

  localparam int WA_W = WA_HI - WA_LO + 1;

  logic [NUM_SEG-1:0][SEG_W-1:0] seg_start, seg_stop;
  logic [NUM_SEG-1:0][EN_W-1:0]  seg_en;
  logic [NUM_SEG-1:0]            hits, armed;
  logic [SEG_W-1:0]              waddr;
  logic                          dword;

  assign waddr = SEG_W'(req_addr[WA_HI:WA_LO]);
  assign dword = (req_size == SZ_DWORD);

  wprot_regs #(
    .NUM_SEG(NUM_SEG), .SEG_W(SEG_W), .EN_W(EN_W),
    .DATA_W(DATA_W), .SEL_W(SEL_W)
  ) i_regs (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel),
    .seg_start(seg_start), .seg_stop(seg_stop), .seg_en(seg_en),
    .cfg_rdata(cfg_rdata), .cfg_err(cfg_err)
  );

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_match
    wprot_seg_match #(.SEG_W(SEG_W), .EN_W(EN_W)) i_match (
      .waddr(waddr), .dword(dword), .super_acc(req_super),
      .seg_start(seg_start[g]), .seg_stop(seg_stop[g]), .seg_en(seg_en[g]),
      .hit(hits[g]), .armed(armed[g])
    );
  end

  wprot_decide #(
    .NUM_SEG(NUM_SEG), .CODE_W(CODE_W), .PROT_CODE(PROT_CODE)
  ) i_decide (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .blk_mode(blk_mode),
    .hits(hits), .armed(armed),
    .resp_valid(resp_valid), .resp_allow(resp_allow),
    .fault_stb(fault_stb), .fault_code(fault_code), .fault_wr(fault_wr)
  );

  // R10: an answer always follows a request by one cycle
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);
  // R10: no request, no answer and no fault
  a_r10_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !fault_stb));
  // R5: the width of the compared address fits inside a segment register
  initial a_r5_width: assert (WA_W <= SEG_W);
endmodule

// File: tb/test_wprot_guard.sv
module test_wprot_guard;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [1:0]  cfg_rsel = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_err;
  logic        blk_mode = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        req_super = 1'b0;
  logic        resp_valid, resp_allow, fault_stb, fault_wr;
  logic [3:0]  fault_code;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit started = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int unsigned m_st[2];
  int unsigned m_ed[2];
  int unsigned m_en[2];
  bit          e_valid, e_allow, e_fault, e_err;
  int unsigned e_rdata;

  always #10 clk = ~clk;  // 50 MHz

  wprot_guard i_wprot_guard (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata),
    .cfg_err(cfg_err), .blk_mode(blk_mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_super(req_super),
    .resp_valid(resp_valid), .resp_allow(resp_allow), .fault_stb(fault_stb),
    .fault_code(fault_code), .fault_wr(fault_wr)
  );

  function automatic bit model_allow(int unsigned addr, int unsigned sz, bit sup, bit blk);
    int unsigned w, wu;
    bit any_en, any_hit;
    w = (addr >> 2) & 32'h1f_ffff;
    wu = (sz == 3) ? (w | 1) : w;
    any_en = 0; any_hit = 0;
    for (int i = 0; i < 2; i++) begin
      if (m_en[i] != 0) any_en = 1;
      if (((m_en[i] >> (sup ? 1 : 0)) & 1) == 1 && w >= m_st[i] && wu < m_ed[i])
        any_hit = 1;
    end
    if (!any_en) return 1'b1;
    if (blk) return !any_hit;
    return any_hit;
  endfunction

  always @(posedge clk) begin
    bit a;
    int unsigned s;
    cyc++;
    started = 1;
    if (rst) begin
      e_valid = 0; e_allow = 0; e_fault = 0; e_err = 0; e_rdata = 0;
      for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_ed[i] = 0; m_en[i] = 0; end
    end else begin
      a = model_allow(req_addr, req_size, req_super, blk_mode);
      e_valid = req_valid;
      e_allow = req_valid && a;
      e_fault = req_valid && !a;
      s = cfg_rsel >> 1;
      e_rdata = cfg_rsel[0] ? m_ed[s] : ((m_en[s] << 23) | m_st[s]);
      e_err = cfg_wr && (cfg_sel[0] ? ((cfg_wdata >> 23) != 0) : ((cfg_wdata >> 25) != 0));
      if (cfg_wr) begin
        s = cfg_sel >> 1;
        if (cfg_sel[0]) m_ed[s] = cfg_wdata & 32'h7f_ffff;
        else begin
          m_st[s] = cfg_wdata & 32'h7f_ffff;
          m_en[s] = (cfg_wdata >> 23) & 3;
        end
      end
    end
  end

  task automatic chk(string tag, string what, int unsigned act, int unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // compare every output on every falling edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(cur_req, "resp_valid", resp_valid, e_valid);        // R10
      chk(cur_req, "resp_allow", resp_allow, e_allow);
      chk("R10", "fault_stb", fault_stb, e_fault);
      chk("R10", "fault_code", fault_code, e_fault ? 4 : 0);
      chk("R10", "fault_wr", fault_wr, e_fault);
      chk("R3", "cfg_err", cfg_err, e_err);
      chk("R2", "cfg_rdata", cfg_rdata, e_rdata);
    end
  end

  task automatic cfg(int unsigned sel, int unsigned data);
    @(negedge clk);
    cfg_wr = 1; cfg_sel = sel[1:0]; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic rd(int unsigned sel);
    @(negedge clk);
    cfg_rsel = sel[1:0];
    @(negedge clk);
  endtask

  task automatic wr_req(int unsigned addr, int unsigned sz, bit sup);
    @(negedge clk);
    req_valid = 1; req_addr = addr; req_size = sz[1:0]; req_super = sup;
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset readback and bypass
    cur_req = "R1";
    for (int i = 0; i < 4; i++) rd(i);
    wr_req(32'h400, 2, 0);
    // R2: program segment 0 user-enabled [0x100,0x110)
    cur_req = "R2";
    cfg(0, (1 << 23) | 32'h100);
    cfg(1, 32'h110);
    cfg(3, 32'h7f_0000);
    for (int i = 0; i < 4; i++) rd(i);
    // R4: in/out of range, end exclusive, high bits ignored
    cur_req = "R4";
    wr_req(32'h400, 2, 0);
    wr_req(32'h43c, 0, 0);
    wr_req(32'h440, 2, 0);
    wr_req(32'h3fc, 1, 0);
    wr_req(32'h0080_0400, 2, 0);
    // R6: supervisor not enabled on segment 0
    cur_req = "R6";
    wr_req(32'h400, 2, 1);
    cfg(2, (2 << 23) | 32'h200);
    wr_req(32'h800, 2, 1);
    wr_req(32'h800, 2, 0);
    // R5: doubleword must fit below end
    cur_req = "R5";
    cfg(1, 32'h10f);
    wr_req(32'h438, 2, 0);
    wr_req(32'h438, 3, 0);
    wr_req(32'h434, 3, 0);
    // R8: allow-only mode miss
    cur_req = "R8";
    wr_req(32'h1000, 2, 0);
    wr_req(32'h1000, 3, 1);
    // R7: block mode
    cur_req = "R7";
    blk_mode = 1;
    wr_req(32'h400, 2, 0);
    wr_req(32'h1000, 2, 0);
    wr_req(32'h800, 3, 1);
    wr_req(32'h800, 3, 0);
    // R3: illegal bits on start and end
    cur_req = "R3";
    cfg(0, (1 << 25) | (1 << 23) | 32'h100);
    cfg(1, (1 << 23) | 32'h10f);
    cfg(2, (3 << 23) | 32'h200);
    cfg(3, 32'h8000_0000);
    for (int i = 0; i < 4; i++) rd(i);
    // R9: both enables cleared, everything passes
    cur_req = "R9";
    cfg(0, 32'h100);
    cfg(2, 32'h200);
    wr_req(32'h400, 2, 0);
    blk_mode = 0;
    wr_req(32'h5000, 3, 1);
    wr_req(32'h400, 0, 1);
    // R1: reset again clears fields
    cur_req = "R1";
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    for (int i = 0; i < 4; i++) rd(i);
    repeat (2) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule